// File: doc/BRIEF.md
# Mute and Pop-Suppression Sequencer for a Two-Channel Switching Amplifier

This block sequences the power-up and power-down of the switching stage of a stereo switching audio amplifier so that the speakers hear no click. It filters the mute request, then runs a timed sequence. On unmute it enables switching, holds the modulator offset at a calibrated starting value, and walks that offset one LSB at a time to the operating value. On mute it walks the offset back before switching is removed. The analog calibration, the modulator and the output stage are outside the block. They appear only as the two offset words it receives and the offset and enable it drives.

A fault-mute input from the protection logic takes the same ramp-down path as a filtered external mute, without the filter delay. A sleep input stops switching at once and parks the ramp. The modulation-mode select and the two gain-select bits are captured only while switching is off, so the modulator never sees a change in mode while it is driving the load.

Top module: `mute_ramp_seq`

## Requirements
- R1: After reset the block is muted: switchEn is 0 and rampDone is 1. With switching off, rampOffset equals dynOffset.
- R2: A change on muteReq is acted on only after DEBOUNCE_CYCLES consecutive clock samples at the new level, plus a fixed synchroniser and sequencer latency of at most four clocks. A pulse shorter than DEBOUNCE_CYCLES has no effect on switchEn.
- R3: On unmute, switchEn rises while rampOffset equals dynOffset, and that value is held for exactly STEP_CYCLES clocks before the first step.
- R4: During the up-ramp, rampOffset moves toward statOffset by exactly one LSB every STEP_CYCLES clocks. Once it equals statOffset, rampDone is 1 and the offset stays constant while unmuted.
- R5: On mute, rampOffset moves back toward dynOffset by one LSB every STEP_CYCLES clocks. switchEn falls only after rampOffset equals dynOffset, and rampDone is 1 once switching is off.
- R6: A mute that arrives during the up-ramp reverses the ramp from its current value. rampOffset never changes by more than one LSB per step while switching.
- R7: When faultMute is 1, the block enters the ramp-down on the next clock, bypassing the mute filter. The offset therefore starts falling within STEP_CYCLES clocks.
- R8: When sleepReq is 1, switchEn is 0 after the next clock edge and rampOffset returns to dynOffset. Switching stays off whatever the mute state is, until sleepReq is 0 again.
- R9: modeLatched copies modeSel only while switchEn is 0. A modeSel change made while switching is ignored until the next period with switching off.
- R10: gainCode copies gainSel under the same rule as R9. gainVv decodes gainCode as follows: 2'b01 gives 12, 2'b10 gives 20, 2'b11 gives 30, and 2'b00 (both pins undriven) gives the lowest gain, 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| muteReq | input | 1 | External mute request, 1 = mute, filtered before use |
| faultMute | input | 1 | Mute from the protection logic, unfiltered |
| sleepReq | input | 1 | Low-power request, 1 = sleep |
| modeSel | input | 1 | Modulation mode: 1 = in-phase filterless, 0 = differential |
| gainSel | input | 2 | Gain select code {msb, lsb} |
| dynOffset | input | OFFSET_W | Calibrated starting offset, signed |
| statOffset | input | OFFSET_W | Operating offset, signed |
| switchEn | output | 1 | Enables output switching |
| rampOffset | output | OFFSET_W | Offset word to the modulator, signed |
| rampDone | output | 1 | 1 when the ramp rests at either end |
| modeLatched | output | 1 | Mode held for the modulator |
| gainCode | output | 2 | Gain code held for the gain stage |
| gainVv | output | 5 | Decoded voltage gain |

## Verification
A wrong sequencer state shows first on switchEn and rampDone. A state that skips the ramp makes switchEn fall while rampOffset is still away from dynOffset, or makes rampDone rise before rampOffset reaches statOffset. Either error appears within one clock of the bad transition. A wrong step counter or direction shows within one STEP_CYCLES interval, as an offset change with the wrong spacing or the wrong sign. A wrong debounce count shifts the switchEn edge by whole clocks after the mute edge, or lets a short glitch through. A wrong capture enable shows as modeLatched or gainCode moving while switchEn is 1.

// File: rtl/mute_ramp_pkg.sv
package mute_ramp_pkg;

  // strobes from the sequencer to the ramp datapath
  typedef struct packed {
    logic load;      // park offset at the calibrated start value
    logic toStat;    // step toward the operating offset
    logic toDyn;     // step toward the calibrated start value
    logic latchCfg;  // capture mode and gain selects
  } rampCmd_t;

  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_UP    = 3'd2,
    ST_RUN   = 3'd3,
    ST_DOWN  = 3'd4
  } seqState_t;

  function automatic logic [4:0] decodeGain(input logic [1:0] code);
    case (code)
      2'b10:   decodeGain = 5'd20;
      2'b11:   decodeGain = 5'd30;
      default: decodeGain = 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/mute_ramp_ctrl.sv
module mute_ramp_ctrl
  import mute_ramp_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 393216
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     muteReq,
  input  logic     faultMute,
  input  logic     sleepReq,
  input  logic     atStat,
  input  logic     atDyn,
  output logic     switchEn,
  output logic     rampDone,
  output rampCmd_t cmd
);

  localparam int DB_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE_CYCLES - 1);

  logic muteS1, muteSync, muteDb;
  logic [DB_W-1:0] dbCnt;
  logic muteEff;
  seqState_t state, stateNext;
  logic pastValid;

  // two-flop synchroniser, reset to the muted level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      muteS1   <= 1'b1;
      muteSync <= 1'b1;
    end else begin
      muteS1   <= muteReq;
      muteSync <= muteS1;
    end
  end

  // accept a new mute level after DEBOUNCE_CYCLES agreeing samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      muteDb <= 1'b1;
      dbCnt  <= '0;
    end else if (muteSync == muteDb) begin
      dbCnt <= '0;
    end else if (dbCnt == DB_LAST) begin
      muteDb <= muteSync;
      dbCnt  <= '0;
    end else begin
      dbCnt <= dbCnt + 1'b1;
    end
  end

  assign muteEff = muteDb | faultMute;

  always_comb begin
    stateNext = state;
    if (sleepReq) begin
      stateNext = ST_SLEEP;
    end else begin
      case (state)
        ST_SLEEP: stateNext = ST_IDLE;
        ST_IDLE:  if (!muteEff) stateNext = ST_UP;
        ST_UP: begin
          if (muteEff)     stateNext = ST_DOWN;
          else if (atStat) stateNext = ST_RUN;
        end
        ST_RUN:   if (muteEff) stateNext = ST_DOWN;
        ST_DOWN: begin
          if (!muteEff)   stateNext = ST_UP;
          else if (atDyn) stateNext = ST_IDLE;
        end
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd          = '0;
    cmd.load     = (state == ST_IDLE) || (state == ST_SLEEP);
    cmd.latchCfg = cmd.load;
    cmd.toStat   = (state == ST_UP);
    cmd.toDyn    = (state == ST_DOWN);
  end

  assign switchEn = (state == ST_UP) || (state == ST_RUN) || (state == ST_DOWN);
  assign rampDone = (state == ST_RUN) || (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R5, R8: switching is removed only at the start value or on sleep
  assert_off_at_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $fell(switchEn)) |-> ($past(atDyn) || $past(sleepReq)));

  // R2: the filtered level only takes a value the synchroniser presented
  assert_debounce_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (muteDb != $past(muteDb))) |-> ($past(muteSync) == muteDb));

  // R8: sleep leaves switching off on the following cycle
  assert_sleep_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !switchEn);

  // R7: a fault while switching never lets the ramp climb further
  assert_fault_down_R7: assert property (@(posedge clk) disable iff (!rstN)
    (faultMute && !sleepReq && switchEn) |=> !cmd.toStat);

endmodule

// File: rtl/mute_ramp_path.sv
module mute_ramp_path
  import mute_ramp_pkg::*;
#(
  parameter int OFFSET_W    = 10,
  parameter int STEP_CYCLES = 2048
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rampCmd_t                   cmd,
  input  logic signed [OFFSET_W-1:0] dynOffset,
  input  logic signed [OFFSET_W-1:0] statOffset,
  input  logic                       modeSel,
  input  logic [1:0]                 gainSel,
  output logic signed [OFFSET_W-1:0] rampOffset,
  output logic                       atStat,
  output logic                       atDyn,
  output logic                       modeLatched,
  output logic [1:0]                 gainCode
);

  localparam int STEP_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYCLES - 1);
  localparam logic [OFFSET_W-1:0] ONE_LSB = OFFSET_W'(1);

  logic [STEP_W-1:0] stepCnt;
  logic signed [OFFSET_W-1:0] curOff, target;
  logic stepping, pastValid;

  assign stepping = cmd.toStat | cmd.toDyn;
  assign target   = cmd.toStat ? statOffset : dynOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curOff  <= '0;
      stepCnt <= '0;
    end else if (cmd.load) begin
      curOff  <= dynOffset;
      stepCnt <= '0;
    end else if (stepping) begin
      if (stepCnt == STEP_LAST) begin
        stepCnt <= '0;
        if (curOff < target)      curOff <= curOff + ONE_LSB;
        else if (curOff > target) curOff <= curOff - ONE_LSB;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end else begin
      stepCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeLatched <= 1'b0;
      gainCode    <= 2'b00;
    end else if (cmd.latchCfg) begin
      modeLatched <= modeSel;
      gainCode    <= gainSel;
    end
  end

  assign rampOffset = curOff;
  assign atStat     = (curOff == statOffset);
  assign atDyn      = (curOff == dynOffset);

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R6: a ramp step never moves the offset by more than one LSB
  assert_single_lsb_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(stepping) && !$past(cmd.load)) |->
      ((rampOffset == $past(rampOffset)) ||
       (rampOffset == $past(rampOffset) + ONE_LSB) ||
       (rampOffset == $past(rampOffset) - ONE_LSB)));

  // R4: the offset holds whenever the sequencer is not ramping or parking
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(stepping) && !$past(cmd.load)) |-> $stable(rampOffset));

endmodule

// File: rtl/mute_ramp_seq.sv
module mute_ramp_seq
  import mute_ramp_pkg::*;
#(
  parameter int OFFSET_W        = 10,
  parameter int DEBOUNCE_CYCLES = 393216,
  parameter int STEP_CYCLES     = 2048
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       muteReq,
  input  logic                       faultMute,
  input  logic                       sleepReq,
  input  logic                       modeSel,
  input  logic [1:0]                 gainSel,
  input  logic signed [OFFSET_W-1:0] dynOffset,
  input  logic signed [OFFSET_W-1:0] statOffset,
  output logic                       switchEn,
  output logic signed [OFFSET_W-1:0] rampOffset,
  output logic                       rampDone,
  output logic                       modeLatched,
  output logic [1:0]                 gainCode,
  output logic [4:0]                 gainVv
);

  rampCmd_t cmd;
  logic atStat, atDyn, pastValid;

  mute_ramp_ctrl #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .muteReq  (muteReq),
    .faultMute(faultMute),
    .sleepReq (sleepReq),
    .atStat   (atStat),
    .atDyn    (atDyn),
    .switchEn (switchEn),
    .rampDone (rampDone),
    .cmd      (cmd)
  );

  mute_ramp_path #(
    .OFFSET_W   (OFFSET_W),
    .STEP_CYCLES(STEP_CYCLES)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .dynOffset  (dynOffset),
    .statOffset (statOffset),
    .modeSel    (modeSel),
    .gainSel    (gainSel),
    .rampOffset (rampOffset),
    .atStat     (atStat),
    .atDyn      (atDyn),
    .modeLatched(modeLatched),
    .gainCode   (gainCode)
  );

  assign gainVv = decodeGain(gainCode);

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R9, R10: configuration never moves while switching continues
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && switchEn && $past(switchEn)) |->
      ($stable(modeLatched) && $stable(gainCode)));

  // R4: a settled unmuted ramp sits on the operating offset
  assert_run_at_stat_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rampDone && switchEn) |-> (rampOffset == statOffset));

endmodule

// File: tb/test_mute_ramp_seq.sv
module test_mute_ramp_seq;

  localparam int W  = 8;
  localparam int DB = 4;
  localparam int K  = 3;

  logic clk = 1'b0;
  logic rstN, muteReq, faultMute, sleepReq, modeSel;
  logic [1:0] gainSel;
  logic signed [W-1:0] dynOffset, statOffset;
  logic switchEn, rampDone, modeLatched;
  logic signed [W-1:0] rampOffset;
  logic [1:0] gainCode;
  logic [4:0] gainVv;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  mute_ramp_seq #(
    .OFFSET_W(W), .DEBOUNCE_CYCLES(DB), .STEP_CYCLES(K)
  ) i_mute_ramp_seq (
    .clk(clk), .rstN(rstN), .muteReq(muteReq), .faultMute(faultMute),
    .sleepReq(sleepReq), .modeSel(modeSel), .gainSel(gainSel),
    .dynOffset(dynOffset), .statOffset(statOffset), .switchEn(switchEn),
    .rampOffset(rampOffset), .rampDone(rampDone), .modeLatched(modeLatched),
    .gainCode(gainCode), .gainVv(gainVv)
  );

  // gain decode vectors: {code, expected V/V}
  localparam logic [6:0] GAIN_VEC [4] = '{
    {2'b01, 5'd12}, {2'b10, 5'd20}, {2'b11, 5'd30}, {2'b00, 5'd12}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // follow a ramp; dir +1 up until settled, -1 down until switching stops
  task automatic trackRamp(input int dir, input bit firstGap, input string req,
                           output int steps, output int lastOn);
    int gap = 0;
    int prev = int'(rampOffset);
    steps = 0;
    lastOn = prev;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      gap++;
      if (!switchEn) break;
      lastOn = int'(rampOffset);
      if (int'(rampOffset) != prev) begin
        check(int'(rampOffset) - prev == dir, req, int'(rampOffset) - prev, dir);
        if (firstGap || steps > 0) check(gap == K, req, gap, K);
        steps++;
        gap = 0;
        prev = int'(rampOffset);
      end
      if (dir > 0 && rampDone) break;
    end
  endtask

  task automatic waitRise(output int n);
    n = 0;
    while (!switchEn && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 100000 && !finished) begin
      finished = 1'b1;
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual %0d expected %0d", cycleCount, 100000);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    int steps, lastOn, n;
    rstN = 1'b0; muteReq = 1'b1; faultMute = 1'b0; sleepReq = 1'b0;
    modeSel = 1'b0; gainSel = 2'b01;
    dynOffset = -8'sd5; statOffset = 8'sd3;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    check(switchEn == 1'b0, "R1 switchEn", switchEn, 0);
    check(rampDone == 1'b1, "R1 rampDone", rampDone, 1);
    check(rampOffset == dynOffset, "R1 offset", rampOffset, dynOffset);

    // R10 gain decode table while muted
    foreach (GAIN_VEC[v]) begin
      gainSel = GAIN_VEC[v][6:5];
      waitCycles(2);
      check(gainCode == GAIN_VEC[v][6:5], "R10 gainCode", gainCode, GAIN_VEC[v][6:5]);
      check(gainVv == GAIN_VEC[v][4:0], "R10 gainVv", gainVv, GAIN_VEC[v][4:0]);
    end
    gainSel = 2'b10;

    // R2 glitch shorter than the filter is ignored
    muteReq = 1'b0;
    waitCycles(DB - 1);
    muteReq = 1'b1;
    waitCycles(2 * DB + 4);
    check(switchEn == 1'b0, "R2 glitch", switchEn, 0);

    // R2/R3 unmute latency and start value
    muteReq = 1'b0;
    waitRise(n);
    check(n >= DB + 1 && n <= DB + 4, "R2 latency", n, DB + 3);
    check(rampOffset == dynOffset, "R3 start value", rampOffset, dynOffset);

    // R4 up-ramp shape
    trackRamp(1, 1'b1, "R4 up-ramp", steps, lastOn);
    check(steps == 8, "R4 step count", steps, 8);
    check(rampOffset == statOffset, "R4 end value", rampOffset, statOffset);
    check(rampDone == 1'b1, "R4 done", rampDone, 1);

    // R9/R10 selects ignored while switching
    modeSel = 1'b1;
    gainSel = 2'b11;
    waitCycles(6);
    check(modeLatched == 1'b0, "R9 mode frozen", modeLatched, 0);
    check(gainCode == 2'b10, "R10 gain frozen", gainCode, 2);
    check(rampOffset == statOffset && switchEn, "R4 hold", rampOffset, statOffset);

    // R5 mute ramps down before switching stops
    muteReq = 1'b1;
    trackRamp(-1, 1'b0, "R5 down-ramp", steps, lastOn);
    check(steps == 8, "R5 step count", steps, 8);
    check(lastOn == int'(dynOffset), "R5 last value", lastOn, dynOffset);
    waitCycles(2);
    check(rampDone == 1'b1, "R5 done", rampDone, 1);
    check(modeLatched == 1'b1, "R9 mode captured", modeLatched, 1);
    check(gainCode == 2'b11, "R10 gain captured", gainCode, 3);

    // R6/R7 fault mid-ramp reverses without a jump
    muteReq = 1'b0;
    waitRise(n);
    n = 0;
    while (int'(rampOffset) != int'(dynOffset) + 3 && n < 200) begin
      @(negedge clk);
      n++;
    end
    faultMute = 1'b1;
    muteReq = 1'b1;
    n = 0;
    while (int'(rampOffset) == int'(dynOffset) + 3 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n <= K, "R7 fault latency", n, K);
    check(int'(rampOffset) == int'(dynOffset) + 2, "R6 reversal", rampOffset, int'(dynOffset) + 2);
    trackRamp(-1, 1'b1, "R6 reversed ramp", steps, lastOn);
    check(lastOn == int'(dynOffset), "R7 last value", lastOn, dynOffset);
    waitCycles(DB + 6);
    faultMute = 1'b0;
    waitCycles(DB + 6);
    check(switchEn == 1'b0, "R7 stays muted", switchEn, 0);

    // R8 sleep stops switching and parks the ramp
    muteReq = 1'b0;
    waitRise(n);
    trackRamp(1, 1'b1, "R4 second ramp", steps, lastOn);
    sleepReq = 1'b1;
    waitCycles(1);
    check(switchEn == 1'b0, "R8 sleep off", switchEn, 1'b0);
    waitCycles(10);
    check(switchEn == 1'b0, "R8 stays off", switchEn, 0);
    check(rampOffset == dynOffset, "R8 parked", rampOffset, dynOffset);
    sleepReq = 1'b0;
    waitRise(n);
    check(n <= 4, "R8 wake", n, 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule